// File: doc/BRIEF.md
# Command/Indicate Channel Transmit Memory

This block keeps one short control primitive for each of sixteen signalling channels. The channels are split into two groups of eight, and each group rides on its own time-division multiplexed serial line. A host reaches the block through a single 16-bit command register with two byte lanes. A write command names a line and a channel and stores a new primitive there. A read command names a line and a channel and captures that channel's current primitive and a small count of how many frames have carried it.

On the serial side, a frame-sync input and a bit-clock enable step a position counter through the frame. Each channel owns a fixed slot of `SLOT_BITS` bit times. Inside the slot a window of width 6 or 4 starts at offset `SLOT_OFS`, and the primitive is shifted out in that window with its most significant bit first. The `wide_mode` input picks the width. Every other bit time is driven high. At each frame start, the primitives committed so far are copied into a transmit snapshot. A commit that arrives mid-frame therefore only shows on the line from the next frame.

With an 8-bit host, the low byte stages the primitive and the high byte carries the address and command. A staged primitive is committed only when the high byte is written with a write command.

Top module: `cind_tx_mem`

## Requirements
- R1: After reset, `bus_rdata` reads 16'h00FF and both serial outputs are high. Every stored primitive is 6'h3F with a count of 0.
- R2: The command word has these fields: bit 14 selects the line, bits 13:11 select the channel, and bit 10 is the command (0 = write, 1 = read). A write with both lanes enabled and bit 10 = 0 stores bits 5:0 as the channel's primitive at once.
- R3: A write with only lane 0 enabled stages bits 5:0 and does not change any stored primitive. A later lane-1 write with bit 10 = 0 commits the staged value to the channel that write addresses.
- R4: A lane-1 write with bit 10 = 1 loads the readback field. The read word is {0, bits 14:10 as last written, 2'b00, count[1:0], primitive[5:0]}. It changes no primitive and no count.
- R5: `bus_rdata` takes a new value only on the cycle after `bus_rd` is high, and bit 15 always reads 0.
- R6: Channel n's window starts at bit position n*SLOT_BITS+SLOT_OFS. With `wide_mode` = 1, bits 5 down to 0 are sent there, most significant first.
- R7: With `wide_mode` = 0, only bits 3 down to 0 are sent, starting at the same position. The two remaining bit times of the window are high.
- R8: Outside every window, and from the end of a frame until the next frame sync, the serial outputs are high.
- R9: A commit clears the channel's count to 0. The count rises by one at the end of each full frame that carried the committed primitive, and it saturates at 3.
- R10: A commit during a frame does not alter that frame, and that frame does not add to the count. The new primitive is sent from the next frame on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is registered |
| bus_be | input | 2 | Byte lane enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data |
| frm_sync | input | 1 | Frame start, taken when `bit_en` is high |
| bit_en | input | 1 | Serial bit-time enable |
| wide_mode | input | 1 | 1 = 6-bit primitives, 0 = 4-bit primitives |
| ser_out | output | 2 | Serial output per line (bit 0 = line 0) |

## Verification
Some rules hold on every cycle and are checked there. Read data holds between read strobes and its top bit stays 0. A read command leaves the stored primitives untouched. A commit zeroes its channel's count, and a saturated count only stays at 3 or returns to 0. The lines stay high while the frame counter is idle. The bench's scenarios are needed for the rest: the bit order and window placement in both widths, the staging over split byte writes, the count rising frame by frame to saturation, and the deferral of a mid-frame commit to the following frame.

// File: rtl/cind_pkg.sv
// Shared constants and types for the command/indicate transmit memory.
// Assumes two serial lines and a 16-bit command word whose field
// positions are fixed by the register layout.
package cind_pkg;
    localparam int MUX_N    = 2;
    localparam int CH_N     = 8;
    localparam int PRIM_W   = 6;
    localparam int NARROW_W = 4;
    localparam int CNT_W    = 2;
    localparam int CH_AW    = $clog2(CH_N);
    localparam int ENT_N    = MUX_N * CH_N;
    localparam int ENT_AW   = $clog2(ENT_N);
    localparam int PIDX_W   = $clog2(PRIM_W);

    typedef logic [PRIM_W-1:0] prim_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Address/command field of the register, bits 14:10
    typedef struct packed {
        logic             mux;
        logic [CH_AW-1:0] ch;
        logic             rd;
    } addr_t;
endpackage

// File: rtl/cind_regif.sv
// Host register front end: decodes byte-lane writes into staging,
// commit and read commands, and holds the registered read word.
// Assumes at most one command per cycle; bus_rd is sampled each clock.
module cind_regif
    import cind_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    input  prim_t             look_prim,
    input  cnt_t              look_cnt,
    output logic [ENT_AW-1:0] look_idx,
    output logic              commit_vld,
    output logic [ENT_AW-1:0] commit_idx,
    output prim_t             commit_prim,
    output logic              read_cmd,
    output logic [15:0]       bus_rdata
);
    addr_t                   addr_q;
    addr_t                   addr_nxt;
    prim_t                   stage_q;
    prim_t                   stage_nxt;
    logic [CNT_W+PRIM_W-1:0] rb_q;
    logic [15:0]             rdata_q;
    logic [15:0]             view;
    logic                    hi_wr;
    logic                    lo_wr;
    logic                    unused_wbits;

    // Decode lane strobes and the command carried in the high byte
    always_comb begin
        hi_wr       = bus_wr & bus_be[1];
        lo_wr       = bus_wr & bus_be[0];
        addr_nxt    = addr_t'(bus_wdata[14:10]);
        stage_nxt   = lo_wr ? bus_wdata[PRIM_W-1:0] : stage_q;
        commit_vld  = hi_wr & ~addr_nxt.rd;
        read_cmd    = hi_wr & addr_nxt.rd;
        commit_idx  = {addr_nxt.mux, addr_nxt.ch};
        look_idx    = {addr_nxt.mux, addr_nxt.ch};
        commit_prim = stage_nxt;
        view        = {1'b0, addr_q, 2'b00, rb_q};
    end

    assign unused_wbits = ^{bus_wdata[15], bus_wdata[9:PRIM_W]};

    // Staging register for the primitive written through lane 0
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= stage_nxt;
    end

    // Address and command field, updated by every lane-1 write
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (hi_wr) addr_q <= addr_nxt;
    end

    // Readback field, captured by a read command
    always_ff @(posedge clk) begin
        if (!rst_n)        rb_q <= '1;
        else if (read_cmd) rb_q <= {look_cnt, look_prim};
    end

    // Registered read data, refreshed on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= 16'h00FF;
        else if (bus_rd) rdata_q <= view;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/cind_store.sv
// Per-channel storage: committed primitive, frame snapshot, and the
// saturating send counter. A commit outranks frame start and frame end
// in the same cycle. Assumes frame_start and frame_end never coincide.
module cind_store
    import cind_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_vld,
    input  logic [ENT_AW-1:0]        commit_idx,
    input  prim_t                    commit_prim,
    input  logic                     frame_start,
    input  logic                     frame_end,
    input  logic [ENT_AW-1:0]        look_idx,
    output prim_t                    look_prim,
    output cnt_t                     look_cnt,
    output logic [ENT_N*PRIM_W-1:0]  act_flat,
    output logic [ENT_N*PRIM_W-1:0]  pend_flat,
    output logic [ENT_N*CNT_W-1:0]   cnt_flat
);
    localparam cnt_t CNT_MAX = '1;

    for (genvar e = 0; e < ENT_N; e++) begin : g_ent
        prim_t pend_r;
        prim_t act_r;
        cnt_t  cnt_r;
        logic  loaded_r;
        logic  hit;

        assign hit = commit_vld && (commit_idx == ENT_AW'(e));

        // Commit, frame snapshot and count update for one channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r   <= '1;
                act_r    <= '1;
                cnt_r    <= '0;
                loaded_r <= 1'b0;
            end else begin
                if (frame_start) begin
                    act_r    <= pend_r;
                    loaded_r <= 1'b1;
                end
                if (frame_end && loaded_r && (cnt_r != CNT_MAX))
                    cnt_r <= cnt_t'(cnt_r + 1'b1);
                if (hit) begin
                    pend_r   <= commit_prim;
                    cnt_r    <= '0;
                    loaded_r <= 1'b0;
                end
            end
        end

        assign act_flat[e*PRIM_W +: PRIM_W]  = act_r;
        assign pend_flat[e*PRIM_W +: PRIM_W] = pend_r;
        assign cnt_flat[e*CNT_W +: CNT_W]    = cnt_r;
    end

    // Lookup for the read command
    assign look_prim = pend_flat[int'(look_idx)*PRIM_W +: PRIM_W];
    assign look_cnt  = cnt_flat[int'(look_idx)*CNT_W +: CNT_W];
endmodule

// File: rtl/cind_framer.sv
// Frame position counter. A sync with the bit enable restarts at 0;
// after the last bit time it parks in an idle state until the next sync.
module cind_framer #(
    parameter int FRAME_BITS = 64,
    localparam int POS_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_sync,
    input  logic             bit_en,
    output logic [POS_W-1:0] pos,
    output logic             frame_start,
    output logic             frame_end,
    output logic             frame_idle
);
    logic [POS_W-1:0] pos_q;

    // Frame boundary events
    always_comb begin
        frame_start = bit_en & frm_sync;
        frame_end   = bit_en & ~frm_sync & (pos_q == POS_W'(FRAME_BITS - 1));
        frame_idle  = (pos_q == POS_W'(FRAME_BITS));
    end

    // Bit position, saturating at the idle value
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= POS_W'(FRAME_BITS);
        else if (frame_start)
            pos_q <= '0;
        else if (bit_en && !frame_idle)
            pos_q <= POS_W'(pos_q + 1'b1);
    end

    assign pos = pos_q;
endmodule

// File: rtl/cind_shifter.sv
// Serialiser for one line: maps the frame position to a channel slot
// and a bit of that channel's snapshot, most significant bit first.
// Assumes SLOT_OFS + PRIM_W <= SLOT_BITS.
module cind_shifter
    import cind_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int SLOT_OFS  = 2,
    localparam int FRAME_BITS = CH_N * SLOT_BITS,
    localparam int POS_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                   wide_mode,
    input  logic [POS_W-1:0]       pos,
    input  logic [CH_N*PRIM_W-1:0] act_row,
    output logic                   sdo
);
    prim_t row [CH_N];

    for (genvar c = 0; c < CH_N; c++) begin : g_row
        assign row[c] = act_row[c*PRIM_W +: PRIM_W];
    end

    // Window test and bit selection for the current bit time
    always_comb begin
        int p;
        int c;
        int o;
        int w;
        int b;
        prim_t cur;
        p   = int'(pos);
        c   = p / SLOT_BITS;
        o   = p % SLOT_BITS;
        w   = wide_mode ? PRIM_W : NARROW_W;
        b   = w - 1 - (o - SLOT_OFS);
        cur = row[CH_AW'(c)];
        if ((p < FRAME_BITS) && (o >= SLOT_OFS) && (o < SLOT_OFS + w))
            sdo = cur[PIDX_W'(b)];
        else
            sdo = 1'b1;
    end
endmodule

// File: rtl/cind_tx_mem.sv
// Top: command/indicate transmit memory for two serial lines of eight
// channels each. Assumes wide_mode is held steady across a frame.
module cind_tx_mem
    import cind_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int SLOT_OFS  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        frm_sync,
    input  logic        bit_en,
    input  logic        wide_mode,
    output logic [1:0]  ser_out
);
    localparam int FRAME_BITS = CH_N * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS + 1);
    localparam int ROW_W      = CH_N * PRIM_W;

    logic [ENT_AW-1:0]       look_idx;
    logic [ENT_AW-1:0]       commit_idx;
    logic                    commit_vld;
    logic                    read_cmd;
    prim_t                   commit_prim;
    prim_t                   look_prim;
    cnt_t                    look_cnt;
    logic [ENT_N*PRIM_W-1:0] act_flat;
    logic [ENT_N*PRIM_W-1:0] pend_flat;
    logic [ENT_N*CNT_W-1:0]  cnt_flat;
    logic [POS_W-1:0]        pos;
    logic                    frame_start;
    logic                    frame_end;
    logic                    frame_idle;

    cind_regif u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_be      (bus_be),
        .bus_wdata   (bus_wdata),
        .look_prim   (look_prim),
        .look_cnt    (look_cnt),
        .look_idx    (look_idx),
        .commit_vld  (commit_vld),
        .commit_idx  (commit_idx),
        .commit_prim (commit_prim),
        .read_cmd    (read_cmd),
        .bus_rdata   (bus_rdata)
    );

    cind_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_vld  (commit_vld),
        .commit_idx  (commit_idx),
        .commit_prim (commit_prim),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .look_idx    (look_idx),
        .look_prim   (look_prim),
        .look_cnt    (look_cnt),
        .act_flat    (act_flat),
        .pend_flat   (pend_flat),
        .cnt_flat    (cnt_flat)
    );

    cind_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_sync    (frm_sync),
        .bit_en      (bit_en),
        .pos         (pos),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_idle  (frame_idle)
    );

    for (genvar g = 0; g < MUX_N; g++) begin : g_line
        cind_shifter #(.SLOT_BITS(SLOT_BITS), .SLOT_OFS(SLOT_OFS)) u_shift (
            .wide_mode (wide_mode),
            .pos       (pos),
            .act_row   (act_flat[g*ROW_W +: ROW_W]),
            .sdo       (ser_out[g])
        );
    end
endmodule

// File: rtl/cind_tx_mem_chk.sv
// Cycle-level checks on the transmit memory, bound to the top module.
module cind_tx_mem_chk
    import cind_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_rd,
    input logic [15:0]             bus_rdata,
    input logic [1:0]              ser_out,
    input logic                    commit_vld,
    input logic [ENT_AW-1:0]       commit_idx,
    input logic                    read_cmd,
    input logic [ENT_N*PRIM_W-1:0] pend_flat,
    input logic [ENT_N*CNT_W-1:0]  cnt_flat,
    input logic                    frame_idle
);
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[15]); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R5

    AST_READ_KEEPS_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
        read_cmd |=> $stable(pend_flat)); // R4

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idle |-> (ser_out == 2'b11)); // R8

    for (genvar e = 0; e < ENT_N; e++) begin : g_chan
        AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_vld && commit_idx == ENT_AW'(e)) |=> (cnt_flat[e*CNT_W +: CNT_W] == '0)); // R9

        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[e*CNT_W +: CNT_W] == '1) |=>
            ((cnt_flat[e*CNT_W +: CNT_W] == '1) || (cnt_flat[e*CNT_W +: CNT_W] == '0))); // R9
    end
endmodule

bind cind_tx_mem cind_tx_mem_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .ser_out    (ser_out),
    .commit_vld (commit_vld),
    .commit_idx (commit_idx),
    .read_cmd   (read_cmd),
    .pend_flat  (pend_flat),
    .cnt_flat   (cnt_flat),
    .frame_idle (frame_idle)
);

// File: tb/cind_tx_mem_tb_top.sv
module cind_tx_mem_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        frm_sync = 1'b0;
    logic        bit_en = 1'b0;
    logic        wide_mode = 1'b1;
    logic [1:0]  ser_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [5:0] m_pend [16];
    logic [5:0] m_act  [16];
    logic [5:0] m_stage;

    always #10 clk = ~clk;

    cind_tx_mem dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frm_sync(frm_sync), .bit_en(bit_en), .wide_mode(wide_mode),
        .ser_out(ser_out)
    );

    // kind: 0 = 16-bit write, 1 = low byte only, 2 = high byte only, 3 = read and check
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 16'h002A, 16'h0000},  // R2 line 0 ch 0 <= 2A
        {2'd3, 16'h0400, 16'h042A},  // R2 R4
        {2'd0, 16'h6815, 16'h0000},  // R2 line 1 ch 5 <= 15
        {2'd3, 16'h6C00, 16'h6C15},  // R2 R4
        {2'd1, 16'h0033, 16'h0000},  // R3 stage only
        {2'd3, 16'h0400, 16'h042A},  // R3 nothing committed
        {2'd2, 16'h3800, 16'h0000},  // R3 commit staged to line 0 ch 7
        {2'd3, 16'h3C00, 16'h3C33},  // R3
        {2'd3, 16'h0C00, 16'h0C3F},  // R1 untouched channel
        {2'd0, 16'hC001, 16'h0000},  // R5 bit 15 written as 1
        {2'd3, 16'hC400, 16'h4401},  // R5 bit 15 reads 0
        {2'd3, 16'h0400, 16'h042A}   // R4 repeated read changes nothing
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [1:0] be, input logic [15:0] d);
        if (be[0]) m_stage = d[5:0];
        if (be[1] && !d[10]) m_pend[{d[14], d[13:11]}] = m_stage;
    endtask

    task automatic bus_write(input logic [1:0] be, input logic [15:0] d);
        bus_wr = 1'b1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
        model_write(be, d);
    endtask

    task automatic read_check(input logic [15:0] cmd, input logic [15:0] exp, input string req);
        bus_write(2'b10, cmd);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    function automatic logic exp_bit(input int g, input int p, input logic wide);
        int c = p / 8;
        int o = p % 8;
        int w = wide ? 6 : 4;
        logic [5:0] v = m_act[g*8 + c];
        if (o >= 2 && o < 2 + w) return v[w - 1 - (o - 2)];
        return 1'b1;
    endfunction

    task automatic run_frame(input logic wide, input int mid_pos, input logic [15:0] mid_word,
                             input string req);
        int bad = 0;
        wide_mode = wide;
        frm_sync = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        frm_sync = 1'b0;
        for (int e = 0; e < 16; e++) m_act[e] = m_pend[e];
        for (int p = 0; p < 64; p++) begin
            for (int g = 0; g < 2; g++)
                if (ser_out[g] !== exp_bit(g, p, wide)) bad++;
            if (p == mid_pos) begin
                bus_wr = 1'b1; bus_be = 2'b11; bus_wdata = mid_word;
            end
            @(negedge clk);
            if (p == mid_pos) begin
                bus_wr = 1'b0; bus_be = 2'b00;
                model_write(2'b11, mid_word);
            end
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; frm_sync = 1'b0; bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < 16; e++) begin m_pend[e] = 6'h3F; m_act[e] = 6'h3F; end
        m_stage = 6'h3F;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state at the ports
        check(bus_rdata === 16'h00FF, "R1 reset rdata", bus_rdata, 16'h00FF);
        check(ser_out === 2'b11, "R1 R8 reset lines", ser_out, 2'b11);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][33:32])
                2'd0: bus_write(2'b11, VEC[i][31:16]);
                2'd1: bus_write(2'b01, VEC[i][31:16]);
                2'd2: bus_write(2'b10, VEC[i][31:16]);
                default: read_check(VEC[i][31:16], VEC[i][15:0], $sformatf("R2/R3/R4/R5 vector %0d", i));
            endcase
        end

        // R6 wide frame, then R9 count rises to 1
        run_frame(1'b1, -1, 16'h0, "R6 wide serial");
        check(ser_out === 2'b11, "R8 idle after frame", ser_out, 2'b11);
        repeat (5) @(negedge clk);
        check(ser_out === 2'b11, "R8 idle held", ser_out, 2'b11);
        read_check(16'h0400, 16'h046A, "R9 count after one frame");
        read_check(16'h3C00, 16'h3C73, "R9 count ch 7");

        // R9 saturation
        run_frame(1'b1, -1, 16'h0, "R6 frame 2");
        run_frame(1'b1, -1, 16'h0, "R6 frame 3");
        run_frame(1'b1, -1, 16'h0, "R6 frame 4");
        read_check(16'h0400, 16'h04EA, "R9 saturate at 3");

        // R7 narrow frame
        run_frame(1'b0, -1, 16'h0, "R7 narrow serial");
        read_check(16'h0400, 16'h04EA, "R9 stays saturated");

        // R10 commit inside channel 0's window at bit 4
        run_frame(1'b1, 4, 16'h000F, "R10 old primitive kept");
        read_check(16'h0400, 16'h040F, "R10 R9 commit clears, frame not counted");
        run_frame(1'b1, -1, 16'h0, "R10 new primitive next frame");
        read_check(16'h0400, 16'h044F, "R10 counted after next frame");

        // R1 reset again restores defaults
        do_reset();
        check(bus_rdata === 16'h00FF, "R1 rdata after reset", bus_rdata, 16'h00FF);
        read_check(16'h0400, 16'h043F, "R1 primitive default");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule